// File: doc/BRIEF.md
# Register-Pair Add Execution Unit

This unit executes the register-pair addition family of an 8-bit-opcode processor whose general registers are 24 bits wide. Opcode bytes arrive one per cycle, qualified by a valid strobe. Up to two prefix bytes may come ahead of the base opcode. The first kind of prefix overrides the operand width for this one instruction. The second kind steers the result into one of the two index registers instead of HL.

When the base opcode arrives, the unit adds the chosen source register into the chosen destination register. The sum is 16 or 24 bits wide. The unit registers the write-back value and the destination code, and updates the flag byte. Only half-carry, subtract and carry change. It also reports how many bytes the instruction took, and raises `done` for one cycle.

A byte that breaks the prefix grammar, or that is not part of the family, raises `illegal` and discards any prefixes collected so far. The register file is outside the unit and is presented on input ports. The current flag byte is also an input.

Top module: `pair_add_unit`

## Requirements
- R1: A base opcode is any byte with bits [7:6]=00 and bits [3:0]=1001 (09, 19, 29, 39 hex). Its bits [5:4] pick the source: 0=BC, 1=DE, 2=HL, 3=SP. The source value is always the plain register named, even when an index prefix is pending.
- R2: With no index prefix the destination is HL. A pending DD hex selects IX and a pending FD hex selects IY. `wb_dst` reports the destination as 0=HL, 1=IX, 2=IY.
- R3: With no width prefix the add is 24-bit when `long_mode` is 1 and 16-bit when it is 0. A pending 52 hex forces 16-bit and a pending 49 hex forces 24-bit, whatever `long_mode` is.
- R4: A 16-bit add writes the sum of the low 16 bits of both operands, with bits [23:16] of `wb_data` cleared. Carry is the carry out of bit 15.
- R5: A 24-bit add writes the full 24-bit sum modulo 2^24. Carry is the carry out of bit 23.
- R6: Half-carry (flag bit 4) is the carry out of bit 11 of the add. Subtract (flag bit 1) is cleared. Carry is flag bit 0.
- R7: Sign (bit 7), zero (bit 6), parity/overflow (bit 2) and the unused bits 5 and 3 of `flags_out` equal those bits of `flags_in` as sampled with the base opcode.
- R8: `cycles` equals 1 plus one for a width prefix plus one for an index prefix, giving 1 to 3.
- R9: `done` is high for exactly the one cycle after the clock edge that accepts a base opcode. `wb_data`, `wb_dst`, `flags_out` and `cycles` are updated in that cycle and hold their values until the next one.
- R10: `illegal` pulses in the cycle after any of these bytes, and `done` stays low:
  - an unrecognised byte;
  - a width prefix after any prefix;
  - a second index prefix.
  The pending prefixes are then discarded, so a following base opcode acts unprefixed.
- R11: During and after synchronous reset, with no instruction since, every output is zero.
- R12: Cycles with `byte_valid` low neither change the prefix state nor produce `done` or `illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | `byte_in` carries an opcode byte this cycle |
| byte_in | input | 8 | Opcode or prefix byte |
| long_mode | input | 1 | Global width mode: 1 = 24-bit, 0 = 16-bit |
| reg_bc | input | 24 | BC register contents |
| reg_de | input | 24 | DE register contents |
| reg_hl | input | 24 | HL register contents |
| reg_sp | input | 24 | SP register contents |
| reg_ix | input | 24 | IX register contents |
| reg_iy | input | 24 | IY register contents |
| flags_in | input | 8 | Current flag byte |
| done | output | 1 | One-cycle completion pulse; write-back valid |
| illegal | output | 1 | One-cycle pulse for a rejected byte |
| wb_dst | output | 2 | Destination register code (0=HL, 1=IX, 2=IY) |
| wb_data | output | 24 | Value to write into the destination |
| flags_out | output | 8 | Updated flag byte |
| cycles | output | 2 | Byte count of the finished instruction |

## Verification
Prefix state that is wrong or stale shows at the ports in the first `done` cycle after the base opcode. It appears as a wrong `wb_dst`, a wrong `cycles`, or a result at the wrong width. A prefix that leaked across an illegal byte shows in the next instruction the same way. Carry or half-carry taken from the wrong bit shows in the same `done` cycle only when operands straddle bits 11, 15 or 23, so the directed cases use exactly those boundaries. Random operands cover every source, destination and width mix.

// File: rtl/pair_add_pkg.sv
package pair_add_pkg;

    // Prefix and opcode byte values
    localparam logic [7:0] PFX_NARROW = 8'h52;
    localparam logic [7:0] PFX_WIDE   = 8'h49;
    localparam logic [7:0] PFX_IX     = 8'hDD;
    localparam logic [7:0] PFX_IY     = 8'hFD;

    // Flag byte bit positions
    localparam int FLG_C = 0;
    localparam int FLG_N = 1;
    localparam int FLG_H = 4;
    localparam logic [7:0] FLG_KEEP_MASK = 8'hEC;

    typedef enum logic [1:0] {
        DST_HL = 2'd0,
        DST_IX = 2'd1,
        DST_IY = 2'd2
    } dst_e;

    typedef enum logic [1:0] {
        WOVR_NONE   = 2'd0,
        WOVR_NARROW = 2'd1,
        WOVR_WIDE   = 2'd2
    } wovr_e;

    typedef enum logic [1:0] {
        SRC_BC = 2'd0,
        SRC_DE = 2'd1,
        SRC_HL = 2'd2,
        SRC_SP = 2'd3
    } src_e;

    typedef struct packed {
        logic       fire;
        logic       bad;
        dst_e       dst;
        src_e       src;
        logic       wide;
        logic [1:0] cycles;
    } op_t;

    function automatic logic is_base_op(input logic [7:0] b);
        return (b[7:6] == 2'b00) && (b[3:0] == 4'b1001);
    endfunction

    function automatic logic is_width_pfx(input logic [7:0] b);
        return (b == PFX_NARROW) || (b == PFX_WIDE);
    endfunction

    function automatic logic is_index_pfx(input logic [7:0] b);
        return (b == PFX_IX) || (b == PFX_IY);
    endfunction

endpackage

// File: rtl/pair_add_decode.sv
module pair_add_decode
    import pair_add_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    input  logic       long_mode,
    output op_t        op
);

    wovr_e pend_w, pend_w_n;
    dst_e  pend_i, pend_i_n;

    always_comb begin
        op        = '0;
        op.dst    = pend_i;
        op.src    = src_e'(byte_in[5:4]);
        pend_w_n  = pend_w;
        pend_i_n  = pend_i;
        if (byte_valid) begin
            if (is_width_pfx(byte_in)) begin
                // width override only legal as the first prefix
                if (pend_w == WOVR_NONE && pend_i == DST_HL) begin
                    pend_w_n = (byte_in == PFX_NARROW) ? WOVR_NARROW : WOVR_WIDE;
                end else begin
                    op.bad   = 1'b1;
                    pend_w_n = WOVR_NONE;
                    pend_i_n = DST_HL;
                end
            end else if (is_index_pfx(byte_in)) begin
                if (pend_i == DST_HL) begin
                    pend_i_n = (byte_in == PFX_IX) ? DST_IX : DST_IY;
                end else begin
                    op.bad   = 1'b1;
                    pend_w_n = WOVR_NONE;
                    pend_i_n = DST_HL;
                end
            end else if (is_base_op(byte_in)) begin
                op.fire = 1'b1;
                case (pend_w)
                    WOVR_NARROW: op.wide = 1'b0;
                    WOVR_WIDE:   op.wide = 1'b1;
                    default:     op.wide = long_mode;
                endcase
                op.cycles = 2'd1
                          + {1'b0, (pend_w != WOVR_NONE)}
                          + {1'b0, (pend_i != DST_HL)};
                pend_w_n = WOVR_NONE;
                pend_i_n = DST_HL;
            end else begin
                op.bad   = 1'b1;
                pend_w_n = WOVR_NONE;
                pend_i_n = DST_HL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_w <= WOVR_NONE;
            pend_i <= DST_HL;
        end else begin
            pend_w <= pend_w_n;
            pend_i <= pend_i_n;
        end
    end

    // R8: byte count never wraps to zero
    p_cycles_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        op.fire |-> (op.cycles != 2'd0));

    // R10: a rejected byte never completes an instruction
    p_bad_not_fire_r10: assert property (@(posedge clk) disable iff (rst)
        op.bad |-> !op.fire);

    // R12: idle cycles keep the pending prefixes
    p_idle_holds_r12: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> ($stable(pend_w) && $stable(pend_i)));

endmodule

// File: rtl/pair_add_alu.sv
module pair_add_alu
    import pair_add_pkg::*;
#(
    parameter int REG_W    = 24,
    parameter int NARROW_W = 16,
    parameter int HC_BIT   = 12
) (
    input  op_t                   op,
    input  logic [3:0][REG_W-1:0] src_bank,
    input  logic [2:0][REG_W-1:0] dst_bank,
    input  logic [7:0]            flags_in,
    output logic [REG_W-1:0]      result,
    output logic [7:0]            flags_new
);

    localparam int PAD_W = REG_W - NARROW_W;

    logic [REG_W-1:0]  a_val, b_val;
    logic [REG_W:0]    sum_wide;
    logic [NARROW_W:0] sum_narrow;
    logic [HC_BIT:0]   sum_half;
    logic              carry;

    always_comb begin
        case (op.dst)
            DST_IX:  a_val = dst_bank[1];
            DST_IY:  a_val = dst_bank[2];
            default: a_val = dst_bank[0];
        endcase
        b_val = src_bank[op.src];
    end

    assign sum_wide   = {1'b0, a_val} + {1'b0, b_val};
    assign sum_narrow = {1'b0, a_val[NARROW_W-1:0]} + {1'b0, b_val[NARROW_W-1:0]};
    assign sum_half   = {1'b0, a_val[HC_BIT-1:0]} + {1'b0, b_val[HC_BIT-1:0]};

    generate
        if (PAD_W > 0) begin : g_pad
            assign result = op.wide ? sum_wide[REG_W-1:0]
                                    : {{PAD_W{1'b0}}, sum_narrow[NARROW_W-1:0]};
        end else begin : g_nopad
            assign result = sum_wide[REG_W-1:0];
        end
    endgenerate

    assign carry = op.wide ? sum_wide[REG_W] : sum_narrow[NARROW_W];

    always_comb begin
        flags_new        = flags_in;
        flags_new[FLG_H] = sum_half[HC_BIT];
        flags_new[FLG_N] = 1'b0;
        flags_new[FLG_C] = carry;
    end

endmodule

// File: rtl/pair_add_unit.sv
module pair_add_unit
    import pair_add_pkg::*;
#(
    parameter int REG_W    = 24,
    parameter int NARROW_W = 16,
    parameter int HC_BIT   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_valid,
    input  logic [7:0]       byte_in,
    input  logic             long_mode,
    input  logic [REG_W-1:0] reg_bc,
    input  logic [REG_W-1:0] reg_de,
    input  logic [REG_W-1:0] reg_hl,
    input  logic [REG_W-1:0] reg_sp,
    input  logic [REG_W-1:0] reg_ix,
    input  logic [REG_W-1:0] reg_iy,
    input  logic [7:0]       flags_in,
    output logic             done,
    output logic             illegal,
    output logic [1:0]       wb_dst,
    output logic [REG_W-1:0] wb_data,
    output logic [7:0]       flags_out,
    output logic [1:0]       cycles
);

    op_t                   op;
    logic [REG_W-1:0]      alu_res;
    logic [7:0]            alu_flags;
    logic [3:0][REG_W-1:0] src_bank;
    logic [2:0][REG_W-1:0] dst_bank;
    logic                  wide_q;

    assign src_bank = {reg_sp, reg_hl, reg_de, reg_bc};
    assign dst_bank = {reg_iy, reg_ix, reg_hl};

    pair_add_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .long_mode  (long_mode),
        .op         (op)
    );

    pair_add_alu #(
        .REG_W    (REG_W),
        .NARROW_W (NARROW_W),
        .HC_BIT   (HC_BIT)
    ) u_alu (
        .op        (op),
        .src_bank  (src_bank),
        .dst_bank  (dst_bank),
        .flags_in  (flags_in),
        .result    (alu_res),
        .flags_new (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            illegal   <= 1'b0;
            wb_dst    <= 2'd0;
            wb_data   <= '0;
            flags_out <= 8'h00;
            cycles    <= 2'd0;
            wide_q    <= 1'b0;
        end else begin
            done    <= op.fire;
            illegal <= op.bad;
            if (op.fire) begin
                wb_dst    <= op.dst;
                wb_data   <= alu_res;
                flags_out <= alu_flags;
                cycles    <= op.cycles;
                wide_q    <= op.wide;
            end
        end
    end

    // R9: a base opcode accepted at an edge completes in the next cycle
    p_base_done_r9: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && is_base_op(byte_in)) |=> done);

    // R10: rejection and completion never coincide
    p_illegal_no_done_r10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !done);

    // R7: untouched flag bits follow the sampled input flags
    p_flags_keep_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> ((flags_out & FLG_KEEP_MASK) == ($past(flags_in) & FLG_KEEP_MASK)));

    // R6: subtract flag is cleared on completion
    p_n_clear_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !flags_out[FLG_N]);

    // R4: narrow results carry nothing above the narrow width
    p_narrow_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !wide_q) |-> (wb_data[REG_W-1:NARROW_W] == '0));

endmodule

// File: tb/pair_add_unit_bench.sv
module pair_add_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        byte_valid;
    logic [7:0]  byte_in;
    logic        long_mode;
    logic [23:0] reg_bc, reg_de, reg_hl, reg_sp, reg_ix, reg_iy;
    logic [7:0]  flags_in;
    logic        done, illegal;
    logic [1:0]  wb_dst, cycles;
    logic [23:0] wb_data;
    logic [7:0]  flags_out;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    pair_add_unit u_pair_add_unit (
        .clk (clk), .rst (rst), .byte_valid (byte_valid), .byte_in (byte_in),
        .long_mode (long_mode),
        .reg_bc (reg_bc), .reg_de (reg_de), .reg_hl (reg_hl), .reg_sp (reg_sp),
        .reg_ix (reg_ix), .reg_iy (reg_iy), .flags_in (flags_in),
        .done (done), .illegal (illegal), .wb_dst (wb_dst), .wb_data (wb_data),
        .flags_out (flags_out), .cycles (cycles)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] src_of(input logic [1:0] ss);
        case (ss)
            2'd0: return reg_bc;
            2'd1: return reg_de;
            2'd2: return reg_hl;
            default: return reg_sp;
        endcase
    endfunction

    function automatic logic [23:0] dst_of(input int isel);
        case (isel)
            1: return reg_ix;
            2: return reg_iy;
            default: return reg_hl;
        endcase
    endfunction

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
    endtask

    task automatic idle;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_in    = 8'h00;
    endtask

    // wsel: 0 none, 1 narrow (52), 2 wide (49); isel: 0 HL, 1 IX (DD), 2 IY (FD)
    task automatic run_add(input int wsel, input int isel, input logic [1:0] ss);
        logic        wide, c, h;
        logic [23:0] a, b, res;
        logic [24:0] s25;
        logic [16:0] s17;
        logic [12:0] s13;
        logic [7:0]  fexp;
        int          ncyc;
        a    = dst_of(isel);
        b    = src_of(ss);
        wide = (wsel == 2) ? 1'b1 : (wsel == 1) ? 1'b0 : long_mode;
        s25  = {1'b0, a} + {1'b0, b};
        s17  = {1'b0, a[15:0]} + {1'b0, b[15:0]};
        s13  = {1'b0, a[11:0]} + {1'b0, b[11:0]};
        res  = wide ? s25[23:0] : {8'h00, s17[15:0]};
        c    = wide ? s25[24] : s17[16];
        h    = s13[12];
        fexp = (flags_in & 8'hEC) | {3'b000, h, 3'b000, c};
        ncyc = 1 + (wsel != 0 ? 1 : 0) + (isel != 0 ? 1 : 0);
        if (wsel == 1) put(8'h52);
        if (wsel == 2) put(8'h49);
        if (isel == 1) put(8'hDD);
        if (isel == 2) put(8'hFD);
        put({2'b00, ss, 4'b1001});
        idle;
        chk("R9 done", done, 1);
        chk("R10 no illegal", illegal, 0);
        chk("R2 wb_dst", wb_dst, isel);
        chk(wide ? "R5 R1 R3 wb_data" : "R4 R1 R3 wb_data", wb_data, res);
        chk(wide ? "R5 carry" : "R4 carry", flags_out[0], c);
        chk("R6 half carry", flags_out[4], h);
        chk("R6 subtract", flags_out[1], 0);
        chk("R7 kept flags", flags_out & 8'hEC, flags_in & 8'hEC);
        chk("R8 cycles", cycles, ncyc);
        idle;
        chk("R9 pulse", done, 0);
        chk("R9 hold data", wb_data, res);
    endtask

    task automatic load_regs(input logic [23:0] v);
        reg_bc = v; reg_de = v; reg_hl = v; reg_sp = v; reg_ix = v; reg_iy = v;
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; byte_valid = 1'b0; byte_in = 8'h00; long_mode = 1'b0;
        load_regs(24'h0); flags_in = 8'h00;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 done", done, 0);
        chk("R11 illegal", illegal, 0);
        chk("R11 wb_data", wb_data, 0);
        chk("R11 flags", flags_out, 0);
        chk("R11 cycles", cycles, 0);
        chk("R11 wb_dst", wb_dst, 0);
        rst = 1'b0;
        idle;
        chk("R11 idle after reset", done, 0);

        // directed carry corners
        flags_in = 8'hFF;
        long_mode = 1'b1;
        load_regs(24'h0); reg_hl = 24'h000FFF; reg_bc = 24'h000001;
        run_add(0, 0, 2'd0);                    // R6 half carry at bit 11
        reg_hl = 24'h00FFFF; reg_de = 24'h000001;
        run_add(1, 0, 2'd1);                    // R4 narrow carry at bit 15
        run_add(0, 0, 2'd1);                    // R5 wide: no carry
        reg_ix = 24'hFFFFFF; reg_sp = 24'h000001;
        run_add(0, 1, 2'd3);                    // R5 carry at bit 23
        reg_iy = 24'hAB8000; reg_hl = 24'h128000;
        long_mode = 1'b0;
        run_add(0, 2, 2'd2);                    // R1 HL source into IY, narrow
        run_add(2, 2, 2'd2);                    // R3 forced wide
        flags_in = 8'h00;
        run_add(2, 0, 2'd2);                    // HL+HL

        // R10 illegal cases
        reg_hl = 24'h000100; reg_bc = 24'h000002; long_mode = 1'b1;
        put(8'h00); idle;
        chk("R10 unknown byte", illegal, 1);
        chk("R10 no done", done, 0);
        put(8'hDD); put(8'h49); idle;
        chk("R10 width after index", illegal, 1);
        run_add(0, 0, 2'd0);                    // R10 prefixes discarded
        put(8'h52); put(8'h52); idle;
        chk("R10 double width", illegal, 1);
        put(8'hFD); put(8'hDD); idle;
        chk("R10 double index", illegal, 1);
        put(8'h49); put(8'h00); idle;
        chk("R10 bad after prefix", illegal, 1);
        run_add(0, 0, 2'd0);

        // R12 gaps keep prefix state
        reg_ix = 24'h123456;
        put(8'h52); put(8'hDD);
        idle; byte_in = 8'h77;
        idle; byte_in = 8'h09;
        chk("R12 no illegal in gap", illegal, 0);
        chk("R12 no done in gap", done, 0);
        put(8'h09); idle;
        chk("R12 dst kept", wb_dst, 1);
        chk("R12 cycles kept", cycles, 3);
        chk("R12 narrow kept", wb_data, {8'h00, 16'h3456 + 16'h0002});
        idle;

        // random mix
        for (int i = 0; i < 300; i++) begin
            reg_bc = $urandom; reg_de = $urandom; reg_hl = $urandom;
            reg_sp = $urandom; reg_ix = $urandom; reg_iy = $urandom;
            flags_in  = $urandom;
            long_mode = $urandom;
            run_add($urandom_range(2), $urandom_range(2), 2'($urandom_range(3)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule